// File: doc/BRIEF.md
# Doubling Programmable Reference Divider

This block divides a reference clock by twice a programmed ratio N. It produces two outputs from that division. One is a square wave at fref/(2N) with a 50% duty cycle. The other is a one-cycle tick that marks each completed period and serves as the comparison-frequency event for a phase detector.

The ratio is an 11-bit word that the programming interface presents on `ratio_i`. The word does not take effect as it changes. It takes effect only when the commit strobe `commit_i` is sampled high. On every commit, the divider state returns to zero, and counting then restarts with the new ratio. This gives a well-defined restart point after each reprogram. The legal ratio range is 3 to 2047, and smaller words are raised to 3.

Top module: `ref_div2n`

## Requirements
- R1: After reset, `sq_o` and `tick_o` are 0 and the active ratio is 3, so the first rising edge of `sq_o` appears 3 cycles after reset is released.
- R2: A committed ratio word of 0, 1 or 2 behaves exactly like a committed ratio of 3.
- R3: After a commit with ratio N (3 to 2047), `sq_o` is 0 for N clock cycles and then 1 for N clock cycles, and this repeats with period 2N.
- R4: A commit at any point in a period forces the counter to zero. In the next cycle `sq_o` and `tick_o` are 0, and the new period starts from there.
- R5: A change on `ratio_i` without a commit has no effect on `sq_o` or `tick_o`.
- R6: `tick_o` is high for exactly one cycle per period. It is high in the cycle where `sq_o` has just fallen from 1 to 0, that is, 2N cycles after each period start.
- R7: While `commit_i` is held high, `sq_o` and `tick_o` stay 0. Counting starts when the strobe drops.
- R8: The largest ratio, 2047, gives a period of 4094 cycles without wrapping the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 11 | Ratio word N, sampled only on a commit |
| commit_i | input | 1 | Commit strobe: zero the divider and load `ratio_i` |
| sq_o | output | 1 | Square wave at fref/(2N), 50% duty |
| tick_o | output | 1 | One-cycle pulse at the end of each period |

## Verification
The bench targets the following cases.
- Ratio words 0, 1 and 2: a design without the clamp would produce a short or degenerate period, or would stall.
- A commit in the middle of a high half-period: a design that failed to zero the counter would finish the old half-period or keep `sq_o` high.
- A change on `ratio_i` with no commit: a design that loaded on every write would shift the period at once.
- A strobe held high for several cycles: this exposes a design that starts counting before the strobe drops.
- Ratio 2047: this shows whether the counter wraps or overflows at the top of the range.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int unsigned RATIO_W_DEF   = 11;
  localparam int unsigned MIN_RATIO_DEF = 3;
  localparam int unsigned RST_RATIO_DEF = 3;
endpackage

// File: rtl/ref_ratio_reg.sv
module ref_ratio_reg #(
  parameter int unsigned W     = 11,
  parameter int unsigned MIN_N = 3,
  parameter int unsigned RST_N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         commit_i,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] ratio_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN_N);
  localparam logic [W-1:0] RST_V = (RST_N < MIN_N) ? W'(MIN_N) : W'(RST_N);

  logic [W-1:0] clamped;
  logic [W-1:0] n_q;

  always_comb clamped = (ratio_i < MIN_V) ? MIN_V : ratio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       n_q <= RST_V;
    else if (commit_i) n_q <= clamped;
  end

  assign ratio_o = n_q;

  // R2: active ratio never below the floor
  a_r2_min_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_o >= MIN_V);
  // R5: ratio moves only on commit
  a_r5_hold_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ratio_o));
endmodule

// File: rtl/ref_half_cnt.sv
module ref_half_cnt #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic [W-1:0] limit_i,
  output logic         half_done_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;
  logic         at_last;

  always_comb begin
    last    = limit_i - W'(1);
    at_last = (cnt_q >= last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (at_last) cnt_q <= '0;
    else              cnt_q <= cnt_q + W'(1);
  end

  assign half_done_o = at_last && !clear_i;

  // R4: commit returns counter to zero
  a_r4_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
  // R8: counter stays inside the half-period
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);
endmodule

// File: rtl/ref_out_stage.sv
module ref_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic half_done_i,
  output logic sq_o,
  output logic tick_o
);
  logic sq_q;
  logic tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q   <= 1'b0;
      tick_q <= 1'b0;
    end else if (clear_i) begin
      sq_q   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (half_done_i) sq_q <= ~sq_q;
      tick_q <= half_done_i & sq_q;  // period ends on the falling half
    end
  end

  assign sq_o   = sq_q;
  assign tick_o = tick_q;

  // R6: tick is a single-cycle pulse
  a_r6_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
  // R6: tick coincides with the square wave having just fallen
  a_r6_tick_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> (!sq_q && $past(sq_q)));
endmodule

// File: rtl/ref_div2n.sv
module ref_div2n
  import ref_div_pkg::*;
#(
  parameter int unsigned RATIO_W   = RATIO_W_DEF,
  parameter int unsigned MIN_RATIO = MIN_RATIO_DEF,
  parameter int unsigned RST_RATIO = RST_RATIO_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               commit_i,
  output logic               sq_o,
  output logic               tick_o
);
  logic [RATIO_W-1:0] n_act;
  logic               half_done;

  ref_ratio_reg #(.W(RATIO_W), .MIN_N(MIN_RATIO), .RST_N(RST_RATIO)) u_ratio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_i),
    .ratio_i  (ratio_i),
    .ratio_o  (n_act)
  );

  ref_half_cnt #(.W(RATIO_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (commit_i),
    .limit_i     (n_act),
    .half_done_o (half_done)
  );

  ref_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (commit_i),
    .half_done_i (half_done),
    .sq_o        (sq_o),
    .tick_o      (tick_o)
  );

  // R4/R7: outputs are low in the cycle after any commit
  a_r7_commit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (!sq_o && !tick_o));
  // R3: square wave only rises from a counted half-period, never on commit
  a_r3_rise_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sq_o) |-> !$past(commit_i));
endmodule

// File: tb/sim_ref_div2n.sv
module sim_ref_div2n;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] ratio = '0;
  logic        commit = 1'b0;
  logic        sq, tick;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string cur_req = "R1";

  // behavioural model: phase within period, active ratio
  int m_n = 3;
  int m_p = 0;
  bit m_tick = 0;

  always #10 clk = ~clk;

  ref_div2n u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ratio_i  (ratio),
    .commit_i (commit),
    .sq_o     (sq),
    .tick_o   (tick)
  );

  function automatic int clampn(int v);
    return (v < 3) ? 3 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 3; m_p = 0; m_tick = 0;
    end else if (commit) begin
      m_n = clampn(int'(ratio)); m_p = 0; m_tick = 0;
    end else begin
      m_p = m_p + 1;
      m_tick = 0;
      if (m_p == 2 * m_n) begin
        m_p = 0; m_tick = 1;
      end
    end
  end

  task automatic check(string req, logic gs, logic es, logic gt, logic et);
    vectors++;
    if (gs !== es || gt !== et) begin
      errors++;
      $display("FAIL %s: sq=%0b exp %0b, tick=%0b exp %0b (cycle %0d)",
               req, gs, es, gt, et, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) check(cur_req, sq, (m_p >= m_n), tick, m_tick);
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: run did not end, actual running exp stopped");
    finish_run();
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_commit(int v, int hold);
    ratio = 11'(v);
    commit = 1'b1;
    run(hold);
    commit = 1'b0;
  endtask

  // count ticks over a window, explicit R6 check
  task automatic tick_count(string req, int win, int exp_ticks);
    int got = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (tick === 1'b1) got++;
    end
    vectors++;
    if (got != exp_ticks) begin
      errors++;
      $display("FAIL %s: tick count=%0d exp %0d", req, got, exp_ticks);
    end
  endtask

  initial begin
    run(3);
    check("R1", sq, 1'b0, tick, 1'b0);   // under reset
    rst_n = 1'b1;
    cur_req = "R1";
    run(20);                             // default ratio 3, period 6

    cur_req = "R3";
    do_commit(5, 1);
    run(40);

    cur_req = "R5";
    ratio = 11'd9;                       // no commit: no effect
    run(30);
    ratio = 11'd0;
    run(12);

    cur_req = "R2";
    do_commit(0, 1); run(20);
    do_commit(1, 1); run(20);
    do_commit(2, 1); run(20);
    do_commit(3, 1); run(20);

    cur_req = "R4";
    do_commit(7, 1);
    run(10);                             // inside high half-period
    do_commit(4, 1);
    run(25);
    do_commit(6, 1);
    run(3);
    do_commit(6, 1);                     // same ratio, restart phase
    run(30);

    cur_req = "R7";
    do_commit(6, 5);
    run(30);

    cur_req = "R6";
    do_commit(12, 1);
    tick_count("R6", 240, 10);

    cur_req = "R8";
    do_commit(2047, 1);
    run(8300);

    cur_req = "R3";
    do_commit(100, 1);
    run(500);

    finish_run();
  end
endmodule